// File: doc/BRIEF.md
# Status Register and Write-Protect Unit

This unit sits beside the command sequencer of a serial nonvolatile memory. It keeps three persistent protection bits: a hardware-lock enable and a two-bit block-protect level. It also keeps the write-enable latch and the busy flag, and it watches the external active-low write-protect pin. From these it builds the status byte that the sequencer shifts out. It also answers two questions at any time: may the array byte at the current address be programmed, and may a status write be accepted?

Status writes go through the same self-timed busy cycle as array writes. The new protection bits are staged while the frame is open. They are committed only when the frame closes, and they take effect only when the timed cycle ends. Serial shifting and array storage belong to other blocks. The sequencer talks to this unit through single-cycle strobes, an address, a data byte and two grant outputs.

Top module: `sr_protect_unit`

## Requirements
- R1: Status byte layout: bit 7 = lock enable, bits 6..4 = 0, bit 3 = BP1, bit 2 = BP0, bit 1 = write-enable latch, bit 0 = busy (1 = write in progress). After reset the byte is 0x00.
- R2: While a self-timed cycle runs, the status byte reads 0xFF and `busy_o` is 1. The cycle lasts exactly WRITE_CYCLES clock cycles.
- R3: `set_wel` sets the write-enable latch and `clr_wel` clears it. `clr_wel` wins if both are given together. The latch is cleared when any self-timed cycle completes.
- R4: Block protection on an array of 2**ADDR_W bytes (default 2048), selected by BP1:BP0. 00 protects nothing. 01 protects the top quarter (0x600-0x7FF). 10 protects the top half (0x400-0x7FF). 11 protects everything. `arr_grant` is 0 for any protected address.
- R5: An unprotected address is granted whenever the latch is 1 and no cycle runs, whatever the lock enable and the pin say.
- R6: `sr_grant` is 1 only when the latch is 1, no cycle runs, and either the lock enable is 0 or `wp_n` is high. A status write that is not granted changes no status bit and starts no cycle.
- R7: A status write takes bits 7, 3 and 2 of `sr_data` and ignores the other bits. The new values appear only when the self-timed cycle ends.
- R8: If `wp_n` falls while `frame_active` is 1 after a status byte was accepted, that status write is dropped when the frame ends. A fall of `wp_n` after the cycle has started has no effect on the update.
- R9: While a cycle runs, every strobe (`set_wel`, `clr_wel`, `sr_load`, `arr_req`) is ignored, and no second cycle follows.
- R10: An `arr_req` that is not granted starts no cycle and leaves the write-enable latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wp_n | input | 1 | External write-protect pin, active low, asynchronous |
| frame_active | input | 1 | High while chip select holds a frame open |
| frame_end | input | 1 | One-cycle strobe when the frame closes |
| set_wel | input | 1 | Strobe: set write-enable latch |
| clr_wel | input | 1 | Strobe: clear write-enable latch |
| sr_load | input | 1 | Strobe: a complete status-write data byte was received |
| sr_data | input | 8 | Status-write data byte |
| arr_req | input | 1 | Strobe: start an array write cycle at `arr_addr` |
| arr_addr | input | ADDR_W | Array address under test |
| status_o | output | 8 | Status byte for the read-status command |
| busy_o | output | 1 | Self-timed cycle in progress |
| arr_grant | output | 1 | Array write at `arr_addr` allowed now |
| sr_grant | output | 1 | Status write allowed now |

## Verification
A wrong protection decode shows at once on `arr_grant` for the boundary addresses of each level. A stuck or lost write-enable latch shows in bit 1 of the status byte in the cycle after the strobe. A mis-timed commit or a miscounted timer shows as a status byte that leaves 0xFF too early or too late, or that returns with the wrong protection bits on the first idle cycle. A broken pin-fall cancel shows as a busy cycle that should never have started, three clocks after the pin moves.

// File: rtl/sr_pkg.sv
package sr_pkg;

  // Protected when the two top address bits fall in the range picked by level
  function automatic logic prot_hit(input logic [1:0] level, input logic [1:0] top2);
    logic hit;
    case (level)
      2'b00:   hit = 1'b0;
      2'b01:   hit = (top2 == 2'b11);
      2'b10:   hit = top2[1];
      default: hit = 1'b1;
    endcase
    return hit;
  endfunction

  // Persistent fields carried by a status write: {lock_en, bp1, bp0}
  function automatic logic [2:0] pick_persist(input logic [7:0] b);
    return {b[7], b[3], b[2]};
  endfunction

endpackage

// File: rtl/sr_sync2.sv
module sr_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/sr_prot_decode.sv
module sr_prot_decode #(
  parameter int ADDR_W = 11
) (
  input  logic [1:0]        level,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  import sr_pkg::*;
  localparam int TOP = ADDR_W - 1;

  always_comb hit = prot_hit(level, addr[TOP -: 2]);
endmodule

// File: rtl/sr_write_timer.sv
module sr_write_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/sr_protect_unit.sv
module sr_protect_unit #(
  parameter int ADDR_W       = 11,
  parameter int WRITE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              frame_active,
  input  logic              frame_end,
  input  logic              set_wel,
  input  logic              clr_wel,
  input  logic              sr_load,
  input  logic [7:0]        sr_data,
  input  logic              arr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        status_o,
  output logic              busy_o,
  output logic              arr_grant,
  output logic              sr_grant
);
  import sr_pkg::*;

  logic rst_int_n;
  logic wp_s, wp_prev_q, wp_fall;

  // persistent bits and latches
  logic       lock_q, lock_d;
  logic [1:0] bp_q, bp_d;
  logic       wel_q, wel_d;
  logic       pend_q, pend_d;
  logic [2:0] pend_bits_q, pend_bits_d;
  logic       sr_cyc_q, sr_cyc_d;
  logic [2:0] stage_q, stage_d;

  logic busy, done, start, prot, hw_lock;

  sr_sync2 #(.RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  sr_sync2 #(.RST_VAL(1'b1)) u_wp_sync (
    .clk(clk), .arst_n(rst_int_n), .d(wp_n), .q(wp_s)
  );

  sr_prot_decode #(.ADDR_W(ADDR_W)) u_decode (
    .level(bp_q), .addr(arr_addr), .hit(prot)
  );

  sr_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .start(start), .busy(busy), .done(done)
  );

  always_comb begin
    wp_fall   = wp_prev_q & ~wp_s;
    hw_lock   = lock_q & ~wp_s;
    arr_grant = wel_q & ~busy & ~prot;
    sr_grant  = wel_q & ~busy & ~hw_lock;
    start     = ~busy & ((arr_req & arr_grant) | (frame_end & pend_q));
  end

  // next state
  always_comb begin
    lock_d      = lock_q;
    bp_d        = bp_q;
    wel_d       = wel_q;
    pend_d      = pend_q;
    pend_bits_d = pend_bits_q;
    sr_cyc_d    = sr_cyc_q;
    stage_d     = stage_q;

    if (done) begin
      wel_d    = 1'b0;
      sr_cyc_d = 1'b0;
      if (sr_cyc_q) begin
        lock_d = stage_q[2];
        bp_d   = stage_q[1:0];
      end
    end else if (!busy) begin
      if (set_wel) wel_d = 1'b1;
      if (clr_wel) wel_d = 1'b0;
    end

    if (start && frame_end && pend_q && !(arr_req && arr_grant)) begin
      sr_cyc_d = 1'b1;
      stage_d  = pend_bits_q;
    end

    if (busy || frame_end || (wp_fall && frame_active)) begin
      pend_d = 1'b0;
    end else if (sr_load && sr_grant) begin
      pend_d      = 1'b1;
      pend_bits_d = pick_persist(sr_data);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      wp_prev_q   <= 1'b1;
      lock_q      <= 1'b0;
      bp_q        <= 2'b00;
      wel_q       <= 1'b0;
      pend_q      <= 1'b0;
      pend_bits_q <= 3'b000;
      sr_cyc_q    <= 1'b0;
      stage_q     <= 3'b000;
    end else begin
      wp_prev_q   <= wp_s;
      lock_q      <= lock_d;
      bp_q        <= bp_d;
      wel_q       <= wel_d;
      pend_q      <= pend_d;
      pend_bits_q <= pend_bits_d;
      sr_cyc_q    <= sr_cyc_d;
      stage_q     <= stage_d;
    end
  end

  assign busy_o   = busy;
  assign status_o = busy ? 8'hFF : {lock_q, 3'b000, bp_q, wel_q, 1'b0};
endmodule

// File: rtl/sr_protect_chk.sv
module sr_protect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status_o,
  input logic       busy_o,
  input logic       arr_grant,
  input logic       sr_grant
);
  // R2
  busy_reads_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> status_o == 8'hFF);

  // R1
  idle_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (status_o[6:4] == 3'b000 && !status_o[0]));

  // R9
  busy_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!arr_grant && !sr_grant));

  // R3
  wel_cleared_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(busy_o)) |-> !status_o[1]);

  // R4
  full_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && status_o[3:2] == 2'b11) |-> !arr_grant);

  // R6
  sr_grant_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_grant |-> status_o[1]);

  // R7
  persist_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !$past(busy_o)) |->
      ({status_o[7], status_o[3:2]} == {$past(status_o[7]), $past(status_o[3:2])}));
endmodule

bind sr_protect_unit sr_protect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .status_o(status_o), .busy_o(busy_o),
  .arr_grant(arr_grant), .sr_grant(sr_grant)
);

// File: tb/sr_protect_unit_test.sv
module sr_protect_unit_test;
  localparam int ADDR_W = 11;
  localparam int WC     = 16;
  localparam int NV     = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1, frame_active = 1'b0, frame_end = 1'b0;
  logic set_wel = 1'b0, clr_wel = 1'b0, sr_load = 1'b0, arr_req = 1'b0;
  logic [7:0] sr_data = 8'h00;
  logic [ADDR_W-1:0] arr_addr = '0;
  logic [7:0] status_o;
  logic busy_o, arr_grant, sr_grant;

  int checks = 0, failures = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  sr_protect_unit #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WC)) uut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .frame_active(frame_active),
    .frame_end(frame_end), .set_wel(set_wel), .clr_wel(clr_wel),
    .sr_load(sr_load), .sr_data(sr_data), .arr_req(arr_req), .arr_addr(arr_addr),
    .status_o(status_o), .busy_o(busy_o), .arr_grant(arr_grant), .sr_grant(sr_grant)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * WC && busy_o; i++) @(negedge clk);
  endtask

  task automatic pulse_wel(input bit set);
    if (set) set_wel = 1'b1; else clr_wel = 1'b1;
    tick(1);
    set_wel = 1'b0; clr_wel = 1'b0;
  endtask

  task automatic wrsr(input logic [7:0] d);
    frame_active = 1'b1; sr_load = 1'b1; sr_data = d;
    tick(1);
    sr_load = 1'b0; frame_active = 1'b0; frame_end = 1'b1;
    tick(1);
    frame_end = 1'b0;
  endtask

  task automatic arr_write(input logic [ADDR_W-1:0] a);
    arr_req = 1'b1;
    tick(1);
    arr_req = 1'b0;
  endtask

  // vector: op[2] wp[1] data[8] addr[11] gnt[1] exp[8] = 31 bits
  // op: 0 set latch, 1 clear latch, 2 status write, 3 array write
  localparam logic [30:0] VEC [NV] = '{
    {2'd0, 1'b1, 8'h00, 11'h000, 1'b0, 8'h02},
    {2'd1, 1'b1, 8'h00, 11'h000, 1'b0, 8'h00},
    {2'd3, 1'b1, 8'h00, 11'h100, 1'b0, 8'h00},
    {2'd0, 1'b1, 8'h00, 11'h000, 1'b0, 8'h02},
    {2'd2, 1'b1, 8'h8C, 11'h000, 1'b1, 8'h8C},
    {2'd0, 1'b1, 8'h00, 11'h000, 1'b0, 8'h8E},
    {2'd3, 1'b1, 8'h00, 11'h000, 1'b0, 8'h8E},
    {2'd2, 1'b1, 8'h04, 11'h000, 1'b1, 8'h04},
    {2'd0, 1'b1, 8'h00, 11'h000, 1'b0, 8'h06},
    {2'd3, 1'b1, 8'h00, 11'h5FF, 1'b1, 8'h04},
    {2'd0, 1'b1, 8'h00, 11'h000, 1'b0, 8'h06},
    {2'd3, 1'b1, 8'h00, 11'h600, 1'b0, 8'h06},
    {2'd2, 1'b1, 8'h88, 11'h000, 1'b1, 8'h88},
    {2'd0, 1'b1, 8'h00, 11'h000, 1'b0, 8'h8A},
    {2'd3, 1'b1, 8'h00, 11'h3FF, 1'b1, 8'h88},
    {2'd0, 1'b1, 8'h00, 11'h000, 1'b0, 8'h8A},
    {2'd3, 1'b1, 8'h00, 11'h400, 1'b0, 8'h8A},
    {2'd2, 1'b0, 8'h00, 11'h000, 1'b0, 8'h8A},
    {2'd3, 1'b0, 8'h00, 11'h100, 1'b1, 8'h88},
    {2'd0, 1'b1, 8'h00, 11'h000, 1'b0, 8'h8A},
    {2'd2, 1'b1, 8'h03, 11'h000, 1'b1, 8'h00},
    {2'd1, 1'b1, 8'h00, 11'h000, 1'b0, 8'h00}
  };

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    chk("R1 reset status", status_o, 8'h00);
    chk("R1 reset busy", {7'd0, busy_o}, 8'h00);
    chk("R6 reset sr_grant", {7'd0, sr_grant}, 8'h00);

    // R3 R4 R5 R6 R7 R10 via table
    for (int v = 0; v < NV; v++) begin
      logic [1:0] op;
      op       = VEC[v][30:29];
      wp_n     = VEC[v][28];
      arr_addr = VEC[v][19:9];
      tick(4);
      if (op == 2'd2) chk($sformatf("R6 sr_grant vec %0d", v), {7'd0, sr_grant}, {7'd0, VEC[v][8]});
      if (op == 2'd3) chk($sformatf("R4 R5 arr_grant vec %0d", v), {7'd0, arr_grant}, {7'd0, VEC[v][8]});
      case (op)
        2'd0: pulse_wel(1'b1);
        2'd1: pulse_wel(1'b0);
        2'd2: wrsr(VEC[v][27:20]);
        default: arr_write(VEC[v][19:9]);
      endcase
      tick(1);
      wait_idle();
      chk($sformatf("R3 R7 R10 status vec %0d", v), status_o, VEC[v][7:0]);
    end

    // R3 clear wins over set
    set_wel = 1'b1; clr_wel = 1'b1; tick(1); set_wel = 1'b0; clr_wel = 1'b0; tick(1);
    chk("R3 clear priority", status_o, 8'h00);

    // R2 busy reads FF, exact length; R9 strobes ignored during cycle; R7 late commit
    pulse_wel(1'b1);
    frame_active = 1'b1; sr_load = 1'b1; sr_data = 8'h0C; tick(1);
    sr_load = 1'b0; tick(1);
    chk("R7 no change before frame end", status_o, 8'h02);
    frame_active = 1'b0; frame_end = 1'b1; tick(1); frame_end = 1'b0;
    chk("R2 busy status", status_o, 8'hFF);
    begin
      int n;
      n = 1;
      set_wel = 1'b1; frame_active = 1'b1; sr_load = 1'b1; sr_data = 8'h80; tick(1);
      n++;
      set_wel = 1'b0; sr_load = 1'b0; frame_active = 1'b0; frame_end = 1'b1; arr_req = 1'b1;
      arr_addr = 11'h000; tick(1); n++;
      frame_end = 1'b0; arr_req = 1'b0;
      while (busy_o && n < 4 * WC) begin tick(1); n++; end
      chk("R2 cycle length", 8'(n - 1), 8'(WC));
    end
    chk("R9 strobes ignored status", status_o, 8'h0C);
    tick(3);
    chk("R9 no second cycle", {7'd0, busy_o}, 8'h00);

    // R8 pin fall during frame cancels
    pulse_wel(1'b1);
    frame_active = 1'b1; sr_load = 1'b1; sr_data = 8'h80; tick(1);
    sr_load = 1'b0; wp_n = 1'b0; tick(5);
    frame_active = 1'b0; frame_end = 1'b1; tick(1); frame_end = 1'b0;
    chk("R8 cancelled no busy", {7'd0, busy_o}, 8'h00);
    chk("R8 cancelled status", status_o, 8'h0E);
    wp_n = 1'b1; tick(4);

    // R8 pin fall after start has no effect
    wrsr(8'h80);
    wp_n = 1'b0;
    tick(2);
    wait_idle();
    chk("R8 fall after start", status_o, 8'h80);
    pulse_wel(1'b1); tick(1);
    chk("R6 locked sr_grant", {7'd0, sr_grant}, 8'h00);
    wrsr(8'h00); tick(2);
    chk("R6 lock keeps enable", status_o, 8'h82);

    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done_flag) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule